// File: doc/BRIEF.md
# Wait and Call Instruction Trap Decider

This block decides what happens to four privileged-control instructions: wait-for-event, wait-for-interrupt, hypervisor call and secure-monitor call. It looks at the instruction kind, the exception level and mode, the security state, whether the condition check passed, whether a wait would really go to sleep, and whether a lower-level trap has already claimed the wait. From these and four configuration controls it returns one of four outcomes. The outcomes are: run normally, raise undefined-instruction, retire as a no-op, or trap to monitor mode.

The decode stage of a core presents the instruction and its context on every cycle. The block returns the outcome code from a register one clock later. Where the architecture allows either an undefined result or a no-op, a compile-time parameter fixes the choice. The block only classifies. It does not model the sleep state or the entry into an exception.

Top module: `wait_call_trap_decider`

## Requirements
- R1: While reset is asserted, `res_code` is 00.
- R2: `res_code` reflects the inputs sampled at the previous rising clock edge. The codes are 00 execute, 01 undefined, 10 no-op and 11 trap to monitor. `instr_kind` is coded 0 wait-for-event, 1 wait-for-interrupt, 2 hypervisor call, 3 secure-monitor call.
- R3: A wait-for-event with `trap_evt_en`=1, or a wait-for-interrupt with `trap_int_en`=1, gives 11 when all four of these hold: the mode is not monitor, the condition passed, the wait would sleep, and no lower trap is raised. The event control has no effect on wait-for-interrupt, and the interrupt control has no effect on wait-for-event.
- R4: A wait instruction issued in monitor mode always gives 00.
- R5: When `cond_pass`=0, every instruction kind gives 00.
- R6: A wait instruction with `would_sleep`=0 gives 00.
- R7: When `lower_trap`=1, a wait instruction gives 00, because the level-1 or level-2 trap takes precedence over the monitor trap.
- R8: A hypervisor call gives 01 in all of these cases: at level 0, when `non_secure`=0, or at level 3.
- R9: A Non-secure hypervisor call at level 1 or 2 gives 00 when `hvc_en`=1. When `hvc_en`=0, it gives 01 at level 1. At level 2 it gives 10 if `HVC_EL2_NOP`=1, and 01 otherwise.
- R10: A secure-monitor call gives 01 at level 0. Above level 0: it gives 00 when `smc_dis`=0. When `smc_dis`=1 it gives 01 in Non-secure state. In Secure state it gives 10 if `SMC_SEC_NOP`=1, and 01 otherwise.
- R11: Hypervisor and secure-monitor calls never give 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_kind | input | 2 | Instruction kind (0 event wait, 1 interrupt wait, 2 hypervisor call, 3 monitor call) |
| cur_el | input | 2 | Current exception level 0..3 |
| in_monitor | input | 1 | Processor is in monitor mode |
| non_secure | input | 1 | Processor is in Non-secure state |
| cond_pass | input | 1 | Instruction passed its condition check |
| would_sleep | input | 1 | A wait would otherwise enter low power |
| lower_trap | input | 1 | A level-1/level-2 trap already claims the wait |
| trap_evt_en | input | 1 | Trap event waits to monitor |
| trap_int_en | input | 1 | Trap interrupt waits to monitor |
| hvc_en | input | 1 | Hypervisor calls enabled |
| smc_dis | input | 1 | Secure-monitor calls disabled |
| res_code | output | 2 | Outcome code |

## Verification
The decision logic is purely combinational. A single output register follows it, so every outcome appears exactly one rising edge after its inputs were applied. The bench changes inputs on the falling edge and compares the output on the next falling edge, half a period after the capturing edge. This means each comparison sees exactly one new decision. The checker applies the same one-edge offset, using `$past` on the inputs together with a primed flag, so that no comparison reaches back to values from before reset.

// File: rtl/wct_pkg.sv
package wct_pkg;
  typedef enum logic [1:0] {
    K_WAIT_EVT = 2'd0,
    K_WAIT_INT = 2'd1,
    K_HYP_CALL = 2'd2,
    K_MON_CALL = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    RES_EXEC  = 2'd0,
    RES_UNDEF = 2'd1,
    RES_NOP   = 2'd2,
    RES_TRAP  = 2'd3
  } res_e;

  localparam int unsigned EL_W = 2;
endpackage

// File: rtl/wct_wait_eval.sv
module wct_wait_eval
  import wct_pkg::*;
(
  input  logic is_evt,
  input  logic trap_evt_en,
  input  logic trap_int_en,
  input  logic in_monitor,
  input  logic would_sleep,
  input  logic lower_trap,
  output res_e res
);
  logic sel_en;
  logic qualified;

  always_comb begin
    sel_en    = is_evt ? trap_evt_en : trap_int_en;
    qualified = would_sleep && !lower_trap && !in_monitor;
    res       = (sel_en && qualified) ? RES_TRAP : RES_EXEC;
  end
endmodule

// File: rtl/wct_hyp_eval.sv
module wct_hyp_eval
  import wct_pkg::*;
#(
  parameter bit EL2_NOP = 1'b1
) (
  input  logic [EL_W-1:0] cur_el,
  input  logic            non_secure,
  input  logic            hvc_en,
  output res_e            res
);
  localparam res_e EL2_OFF_RES = EL2_NOP ? RES_NOP : RES_UNDEF;

  always_comb begin
    res = RES_UNDEF;
    if (non_secure) begin
      unique case (cur_el)
        2'd1:    res = hvc_en ? RES_EXEC : RES_UNDEF;
        2'd2:    res = hvc_en ? RES_EXEC : EL2_OFF_RES;
        default: res = RES_UNDEF;
      endcase
    end
  end
endmodule

// File: rtl/wct_mon_eval.sv
module wct_mon_eval
  import wct_pkg::*;
#(
  parameter bit SEC_NOP = 1'b0
) (
  input  logic is_el0,
  input  logic non_secure,
  input  logic smc_dis,
  output res_e res
);
  localparam res_e SEC_OFF_RES = SEC_NOP ? RES_NOP : RES_UNDEF;

  always_comb begin
    if (is_el0)          res = RES_UNDEF;
    else if (!smc_dis)   res = RES_EXEC;
    else if (non_secure) res = RES_UNDEF;
    else                 res = SEC_OFF_RES;
  end
endmodule

// File: rtl/wait_call_trap_decider.sv
module wait_call_trap_decider
  import wct_pkg::*;
#(
  parameter bit HVC_EL2_NOP = 1'b1,
  parameter bit SMC_SEC_NOP = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] instr_kind,
  input  logic [1:0] cur_el,
  input  logic       in_monitor,
  input  logic       non_secure,
  input  logic       cond_pass,
  input  logic       would_sleep,
  input  logic       lower_trap,
  input  logic       trap_evt_en,
  input  logic       trap_int_en,
  input  logic       hvc_en,
  input  logic       smc_dis,
  output logic [1:0] res_code
);
  kind_e kind;
  res_e  wait_res, hyp_res, mon_res;
  res_e  res_d, res_q;
  logic  res_en;

  assign kind = kind_e'(instr_kind);

  wct_wait_eval i_wait (
    .is_evt      (kind == K_WAIT_EVT),
    .trap_evt_en (trap_evt_en),
    .trap_int_en (trap_int_en),
    .in_monitor  (in_monitor),
    .would_sleep (would_sleep),
    .lower_trap  (lower_trap),
    .res         (wait_res)
  );

  wct_hyp_eval #(.EL2_NOP(HVC_EL2_NOP)) i_hyp (
    .cur_el     (cur_el),
    .non_secure (non_secure),
    .hvc_en     (hvc_en),
    .res        (hyp_res)
  );

  wct_mon_eval #(.SEC_NOP(SMC_SEC_NOP)) i_mon (
    .is_el0     (cur_el == 2'd0),
    .non_secure (non_secure),
    .smc_dis    (smc_dis),
    .res        (mon_res)
  );

  // next-state selection
  always_comb begin
    res_en = 1'b1;
    if (!cond_pass) begin
      res_d = RES_EXEC;
    end else begin
      unique case (kind)
        K_WAIT_EVT, K_WAIT_INT: res_d = wait_res;
        K_HYP_CALL:             res_d = hyp_res;
        default:                res_d = mon_res;
      endcase
    end
  end

  // outcome register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= RES_EXEC;
    else if (res_en) res_q <= res_d;
  end

  assign res_code = res_q;
endmodule

// File: rtl/wct_checker.sv
module wct_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] instr_kind,
  input logic [1:0] cur_el,
  input logic       in_monitor,
  input logic       non_secure,
  input logic       cond_pass,
  input logic       would_sleep,
  input logic       lower_trap,
  input logic [1:0] res_code
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  logic is_wait, is_call;
  assign is_wait = !instr_kind[1];
  assign is_call = instr_kind[1];

  always_comb begin
    if (!rst_n) AST_RESET_EXEC: assert (res_code == 2'd0); // R1
  end

  AST_CALL_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(is_call) |-> res_code != 2'd3); // R11
  AST_COND_FAIL_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !$past(cond_pass) |-> res_code == 2'd0); // R5
  AST_MONITOR_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(is_wait && in_monitor) |-> res_code == 2'd0); // R4
  AST_AWAKE_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(is_wait && !would_sleep) |-> res_code == 2'd0); // R6
  AST_LOWER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(is_wait && lower_trap) |-> res_code == 2'd0); // R7
  AST_HYP_SECURE_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(instr_kind == 2'd2 && cond_pass && (!non_secure || cur_el == 2'd0))
      |-> res_code == 2'd1); // R8
  AST_MON_EL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(instr_kind == 2'd3 && cond_pass && cur_el == 2'd0)
      |-> res_code == 2'd1); // R10
endmodule

bind wait_call_trap_decider wct_checker i_wct_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_kind  (instr_kind),
  .cur_el      (cur_el),
  .in_monitor  (in_monitor),
  .non_secure  (non_secure),
  .cond_pass   (cond_pass),
  .would_sleep (would_sleep),
  .lower_trap  (lower_trap),
  .res_code    (res_code)
);

// File: tb/test_wait_call_trap_decider.sv
`timescale 1ns/1ps
module test_wait_call_trap_decider;
  localparam bit P_HVC_NOP = 1'b1;
  localparam bit P_SMC_NOP = 1'b0;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] kind, el, res;
  logic mon, ns, cp, ws, lt, te, ti, he, sd;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wait_call_trap_decider #(.HVC_EL2_NOP(P_HVC_NOP), .SMC_SEC_NOP(P_SMC_NOP)) i_wait_call_trap_decider (
    .clk(clk), .rst_n(rst_n), .instr_kind(kind), .cur_el(el), .in_monitor(mon),
    .non_secure(ns), .cond_pass(cp), .would_sleep(ws), .lower_trap(lt),
    .trap_evt_en(te), .trap_int_en(ti), .hvc_en(he), .smc_dis(sd), .res_code(res)
  );

  function automatic logic [1:0] model();
    if (!cp) return 2'd0;
    case (kind)
      2'd0, 2'd1: begin
        logic en;
        en = (kind == 2'd0) ? te : ti;
        return (en && !mon && ws && !lt) ? 2'd3 : 2'd0;
      end
      2'd2: begin
        if (!ns || el == 2'd0 || el == 2'd3) return 2'd1;
        if (he) return 2'd0;
        if (el == 2'd1) return 2'd1;
        return P_HVC_NOP ? 2'd2 : 2'd1;
      end
      default: begin
        if (el == 2'd0) return 2'd1;
        if (!sd) return 2'd0;
        if (ns) return 2'd1;
        return P_SMC_NOP ? 2'd2 : 2'd1;
      end
    endcase
  endfunction

  task automatic check(input logic [1:0] exp, input string req);
    n_run++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (kind=%0d el=%0d)", req, res, exp, kind, el);
    end
  endtask

  // drive at falling edge, compare at next falling edge (one register)
  task automatic apply(input logic [1:0] k, input logic [1:0] e, input logic m, input logic n,
                       input logic c, input logic w, input logic l, input logic a,
                       input logic b, input logic h, input logic s, input string req);
    logic [1:0] exp;
    kind = k; el = e; mon = m; ns = n; cp = c; ws = w; lt = l; te = a; ti = b; he = h; sd = s;
    exp = model();
    @(negedge clk);
    check(exp, req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    kind = 2'd0; el = 2'd1; mon = 0; ns = 1; cp = 1; ws = 1; lt = 0; te = 1; ti = 1; he = 0; sd = 0;
    repeat (3) @(negedge clk);
    check(2'd0, "R1");
    rst_n = 1'b1;
    // R3 / R2: traps per kind, controls cross-independent
    apply(2'd0, 2'd1, 0, 1, 1, 1, 0, 1, 0, 0, 0, "R3");
    check(2'd3, "R2");
    apply(2'd1, 2'd1, 0, 1, 1, 1, 0, 1, 0, 0, 0, "R3");
    apply(2'd1, 2'd0, 0, 0, 1, 1, 0, 0, 1, 0, 0, "R3");
    apply(2'd0, 2'd2, 0, 1, 1, 1, 0, 0, 1, 0, 0, "R3");
    apply(2'd0, 2'd3, 1, 0, 1, 1, 0, 1, 1, 0, 0, "R4");
    apply(2'd1, 2'd1, 0, 1, 0, 1, 0, 1, 1, 0, 0, "R5");
    apply(2'd3, 2'd0, 0, 1, 0, 1, 0, 0, 0, 0, 1, "R5");
    apply(2'd0, 2'd1, 0, 1, 1, 0, 0, 1, 1, 0, 0, "R6");
    apply(2'd1, 2'd2, 0, 1, 1, 1, 1, 1, 1, 0, 0, "R7");
    apply(2'd2, 2'd0, 0, 1, 1, 1, 0, 0, 0, 1, 0, "R8");
    apply(2'd2, 2'd1, 0, 0, 1, 1, 0, 0, 0, 1, 0, "R8");
    apply(2'd2, 2'd3, 0, 1, 1, 1, 0, 0, 0, 1, 0, "R8");
    apply(2'd2, 2'd1, 0, 1, 1, 1, 0, 0, 0, 1, 0, "R9");
    apply(2'd2, 2'd1, 0, 1, 1, 1, 0, 0, 0, 0, 0, "R9");
    apply(2'd2, 2'd2, 0, 1, 1, 1, 0, 0, 0, 0, 0, "R9");
    apply(2'd3, 2'd0, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R10");
    apply(2'd3, 2'd1, 0, 1, 1, 1, 0, 0, 0, 0, 0, "R10");
    apply(2'd3, 2'd2, 0, 1, 1, 1, 0, 0, 0, 0, 1, "R10");
    apply(2'd3, 2'd3, 0, 0, 1, 1, 0, 0, 0, 0, 1, "R10");
    apply(2'd2, 2'd2, 0, 1, 1, 1, 0, 1, 1, 0, 1, "R11");
    begin
      int unsigned seed;
      logic [12:0] r;
      seed = 32'd1234;
      r = 13'($urandom(seed));
      for (int i = 0; i < 3000; i++) begin
        r = 13'($urandom());
        apply(r[1:0], r[3:2], r[4], r[5], (r[6] | r[7]), r[8], r[9] & r[10],
              r[11], r[12], r[6], r[10], "R2 random");
      end
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule